// File: doc/BRIEF.md
# Two-Wire Register Slave with Coherent Temperature Snapshot

This block is a slave on a two-wire serial bus (I2C style) that serves four byte-wide registers. Two of them form a 16-bit read/write frequency-tuning word, driven straight out on `tune_word`. The other two present a read-only 12-bit temperature code. Both bus lines come in as raw levels and are synchronized by a fast system clock. The block pulls SDA low only through an open-drain enable, `sda_oe`. The block recognizes START, repeated START and STOP, compares the 7-bit device address and acknowledges bytes. It keeps a register pointer that advances on every byte moved.

The temperature source outside the block delivers a code with a one-cycle valid strobe, and that code is held in a live copy. The bus does not read the live copy. It reads a separate visible copy, which is refreshed from the live one at two moments only: when an address byte with write direction is acknowledged, and when a register-pointer byte arrives. Reads never refresh it. A master that sets the pointer and then reads both temperature bytes in one burst therefore gets two halves of the same sample. One cycle after reset a conversion request is pulsed.

Top module: `i2c_tune_temp_slave`

## Requirements
- R1: After reset `tune_word` is 0x0000, `sda_oe` is low, and the visible temperature reads as code 0x190 (register 2 returns 0x19, register 3 returns 0x00).
- R2: A falling SDA while SCL is high (START) starts address reception from any state. A rising SDA while SCL is high (STOP) returns the slave to idle with SDA released.
- R3: `conv_req` is high for exactly one clock cycle shortly after reset is released, and stays low after that.
- R4: The visible temperature copy takes the live value when an address byte with write direction is acknowledged, and when a pointer byte is received. Reads and `temp_valid` strobes do not change it on their own.
- R5: A data byte written to register 0 sets `tune_word[15:8]` and one written to register 1 sets `tune_word[7:0]`. Bytes written to registers 2 and 3 are acknowledged and leave all register contents unchanged.
- R6: The first byte after START holds the device address in bits 7:1 and the direction in bit 0 (1 = read). A matching address is acknowledged. On a mismatch the slave sends no acknowledge and keeps SDA released until the next START.
- R7: The first byte written after an address with write direction sets the pointer to its bits 1:0. Each data byte written or read then moves the pointer up by one, and it wraps from 3 to 0.
- R8: Bytes travel MSB first with the acknowledge on the ninth clock, and `sda_oe` changes only while SCL is low.
- R9: When the master does not acknowledge a byte it has read, the slave stops sending and keeps SDA released for any further clocks until the next START or STOP.
- R10: Register 2 returns temperature bits 11:4. Register 3 returns bits 3:0 in its bits 7:4, and its bits 3:0 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw level of the bus clock line |
| sda_in | input | 1 | Raw level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| temp_code | input | 12 | New temperature code, two's complement, 1/16 degree per LSB |
| temp_valid | input | 1 | One-cycle strobe marking `temp_code` valid |
| conv_req | output | 1 | One-cycle request for a temperature conversion after reset |
| tune_word | output | 16 | Frequency tuning word {register 0, register 1} |

## Verification
The assertions check every cycle that the data-line enable and the tuning word change only while SCL is low, that SDA is released right after a STOP, that the conversion request never lasts more than one cycle, and that the visible temperature moves only in the cycle after a snapshot command from the bus engine. The scenarios alone show what depends on whole transactions. These cover address matching and rejection, pointer setting and wrap, writes that are ignored, and the master's NACK ending a read. They also cover the coherent snapshot: a live update between a pointer write and a later read-only access must not reach the bus.

// File: rtl/i2c_tt_pkg.sv
package i2c_tt_pkg;

    localparam int BYTE_W  = 8;
    localparam int REG_NUM = 4;
    localparam int PTR_W   = $clog2(REG_NUM);
    localparam int TUNE_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } bus_state_t;

    // Command from the bus engine to the register file, one-cycle pulses.
    typedef struct packed {
        logic              snap;
        logic              set_ptr;
        logic              wr;
        logic              rd_adv;
        logic [BYTE_W-1:0] data;
    } reg_cmd_t;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return p + 1'b1;
    endfunction

endpackage

// File: rtl/i2c_tt_line_sync.sv
module i2c_tt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_tt_engine.sv
module i2c_tt_engine
    import i2c_tt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output reg_cmd_t          cmd
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    bus_state_t        state;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [3:0]        cnt;
    logic              is_read;
    logic              want_ptr;
    logic              m_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            tx       <= '0;
            cnt      <= '0;
            is_read  <= 1'b0;
            want_ptr <= 1'b0;
            m_ack    <= 1'b0;
            sda_oe   <= 1'b0;
            cmd      <= '0;
        end else begin
            cmd <= '0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                sda_oe  <= 1'b1;
                                is_read <= shreg[0];
                                state   <= ST_ADDR_ACK;
                                if (!shreg[0]) begin
                                    cmd.snap <= 1'b1;
                                    want_ptr <= 1'b1;
                                end
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (is_read) begin
                                tx         <= rd_byte;
                                sda_oe     <= ~rd_byte[BYTE_W-1];
                                cmd.rd_adv <= 1'b1;
                                state      <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            sda_oe   <= 1'b1;
                            state    <= ST_WR_ACK;
                            cmd.data <= shreg;
                            if (want_ptr) begin
                                cmd.set_ptr <= 1'b1;
                                cmd.snap    <= 1'b1;
                                want_ptr    <= 1'b0;
                            end else begin
                                cmd.wr <= 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (cnt == LAST_BIT - 1'b1) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (m_ack) begin
                                tx         <= rd_byte;
                                sda_oe     <= ~rd_byte[BYTE_W-1];
                                cmd.rd_adv <= 1'b1;
                                state      <= ST_RD;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_tt_regs.sv
module i2c_tt_regs
    import i2c_tt_pkg::*;
#(
    parameter int              TEMP_W     = 12,
    parameter logic [TEMP_W-1:0] RESET_TEMP = 12'h190
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              temp_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [TUNE_W-1:0] tune_word,
    output logic [TEMP_W-1:0] shown_temp,
    output logic              conv_req
);
    localparam int LOW_BITS = TEMP_W - BYTE_W;

    logic [BYTE_W-1:0] tune_q [2];
    logic [TEMP_W-1:0] live_temp;
    logic [PTR_W-1:0]  ptr;
    logic              armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            tune_q[0]  <= '0;
            tune_q[1]  <= '0;
            live_temp  <= RESET_TEMP;
            shown_temp <= RESET_TEMP;
            ptr        <= '0;
            armed      <= 1'b1;
            conv_req   <= 1'b0;
        end else begin
            conv_req <= armed;
            armed    <= 1'b0;
            if (temp_valid) begin
                live_temp <= temp_code;
            end
            if (cmd.snap) begin
                shown_temp <= live_temp;
            end
            if (cmd.set_ptr) begin
                ptr <= cmd.data[PTR_W-1:0];
            end else if (cmd.wr) begin
                if (!ptr[PTR_W-1]) begin
                    tune_q[ptr[0]] <= cmd.data;
                end
                ptr <= ptr_step(ptr);
            end else if (cmd.rd_adv) begin
                ptr <= ptr_step(ptr);
            end
        end
    end

    always_comb begin
        case (ptr)
            2'd0:    rd_byte = tune_q[0];
            2'd1:    rd_byte = tune_q[1];
            2'd2:    rd_byte = shown_temp[TEMP_W-1 -: BYTE_W];
            default: rd_byte = {shown_temp[LOW_BITS-1:0], {(BYTE_W-LOW_BITS){1'b0}}};
        endcase
    end

    assign tune_word = {tune_q[0], tune_q[1]};

endmodule

// File: rtl/i2c_tune_temp_slave.sv
module i2c_tune_temp_slave
    import i2c_tt_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h4C,
    parameter int                SYNC_STAGES = 2,
    parameter int                TEMP_W      = 12,
    parameter logic [TEMP_W-1:0] RESET_TEMP  = 12'h190
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              temp_valid,
    output logic              conv_req,
    output logic [TUNE_W-1:0] tune_word
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] rd_byte;
    logic [TEMP_W-1:0] shown_temp;
    logic              snap_pulse;
    reg_cmd_t          cmd;

    i2c_tt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_tt_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_oe),
        .cmd      (cmd)
    );

    i2c_tt_regs #(.TEMP_W(TEMP_W), .RESET_TEMP(RESET_TEMP)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .temp_code (temp_code),
        .temp_valid(temp_valid),
        .rd_byte   (rd_byte),
        .tune_word (tune_word),
        .shown_temp(shown_temp),
        .conv_req  (conv_req)
    );

    assign snap_pulse = cmd.snap;

endmodule

// File: rtl/i2c_tt_chk.sv
module i2c_tt_chk #(
    parameter int TEMP_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_in,
    input logic              sda_oe,
    input logic              conv_req,
    input logic              stop_seen,
    input logic              snap_pulse,
    input logic [15:0]       tune_word,
    input logic [TEMP_W-1:0] shown_temp
);
    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_in);

    // R5
    tune_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tune_word) |-> !scl_in);

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(stop_seen) |-> !sda_oe);

    // R3
    conv_single_chk: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req);

    // R4
    snap_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(shown_temp) |-> $past(snap_pulse));

endmodule

bind i2c_tune_temp_slave i2c_tt_chk #(.TEMP_W(TEMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .conv_req  (conv_req),
    .stop_seen (stop_det),
    .snap_pulse(snap_pulse),
    .tune_word (tune_word),
    .shown_temp(shown_temp)
);

// File: tb/test_i2c_tune_temp_slave.sv
module test_i2c_tune_temp_slave;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 16;
    localparam logic [6:0] DEV = 7'h4C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [11:0] temp_code = 12'h000;
    logic        temp_valid = 1'b0;
    logic        conv_req;
    logic [15:0] tune_word;

    int checks = 0;
    int errors = 0;
    int conv_cnt = 0;
    int oe_hits = 0;
    bit bus_idle = 1'b1;
    logic prev_oe = 1'b0;

    // Reference model state
    logic [7:0]  exp_reg [4];
    int          exp_ptr = 0;
    logic [11:0] exp_live = 12'h190;
    logic [11:0] exp_shown = 12'h190;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_tune_temp_slave #(.DEV_ADDR(DEV)) i_i2c_tune_temp_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .temp_code (temp_code),
        .temp_valid(temp_valid),
        .conv_req  (conv_req),
        .tune_word (tune_word)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] view(input int p);
        case (p)
            0:       return exp_reg[0];
            1:       return exp_reg[1];
            2:       return exp_shown[11:4];
            default: return {exp_shown[3:0], 4'h0};
        endcase
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (conv_req) conv_cnt++;
            if (sda_oe) oe_hits++;
            if (sda_oe !== prev_oe && scl)
                check(1'b0, "R8 oe change with SCL high", sda_oe, prev_oe);
            if (bus_idle)
                check(tune_word == {exp_reg[0], exp_reg[1]}, "R5 idle tune_word",
                      tune_word, {exp_reg[0], exp_reg[1]});
        end
        prev_oe = sda_oe;
    end

    task automatic m_start();
        bus_idle = 1'b0;
        sda_m = 1'b1; wclk(H);
        scl = 1'b1;   wclk(H);
        sda_m = 1'b0; wclk(H);
        scl = 1'b0;   wclk(H);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wclk(H);
        scl = 1'b1;   wclk(H);
        sda_m = 1'b1; wclk(H);
        bus_idle = 1'b1;
        check(sda_oe == 1'b0, "R2 released after STOP", sda_oe, 0);
    endtask

    task automatic m_write(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(H);
            scl = 1'b1;   wclk(H);
            scl = 1'b0;   wclk(2);
        end
        sda_m = 1'b1; wclk(H);
        scl = 1'b1;   wclk(H/2);
        ack = !sda_line;
        wclk(H/2);
        scl = 1'b0;   wclk(2);
    endtask

    task automatic m_read(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wclk(H);
            scl = 1'b1;   wclk(H/2);
            b[i] = sda_line;
            wclk(H/2);
            scl = 1'b0;   wclk(2);
        end
        sda_m = nack; wclk(H);
        scl = 1'b1;   wclk(H);
        scl = 1'b0;   wclk(2);
        sda_m = 1'b1;
    endtask

    task automatic x_addr(input logic [6:0] a, input bit rd, input bit exp_ack, input string req);
        bit ack;
        m_write({a, rd}, ack);
        check(ack == exp_ack, req, ack, exp_ack);
        if (ack && !rd) exp_shown = exp_live;
    endtask

    task automatic x_ptr(input logic [7:0] w);
        bit ack;
        m_write(w, ack);
        check(ack, "R7 pointer byte ack", ack, 1);
        exp_ptr = int'(w[1:0]);
        exp_shown = exp_live;
    endtask

    task automatic x_wr(input logic [7:0] d, input string req);
        bit ack;
        m_write(d, ack);
        check(ack, req, ack, 1);
        if (exp_ptr < 2) exp_reg[exp_ptr] = d;
        exp_ptr = (exp_ptr + 1) % 4;
    endtask

    task automatic x_rd(input bit last, input string req);
        logic [7:0] b;
        m_read(last, b);
        check(b == view(exp_ptr), req, b, view(exp_ptr));
        exp_ptr = (exp_ptr + 1) % 4;
    endtask

    task automatic push_temp(input logic [11:0] code);
        temp_code = code;
        temp_valid = 1'b1;
        wclk(1);
        temp_valid = 1'b0;
        exp_live = code;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        bit ack;
        exp_reg[0] = 8'h00; exp_reg[1] = 8'h00;
        exp_reg[2] = 8'h00; exp_reg[3] = 8'h00;
        wclk(5);
        rst = 1'b0;
        wclk(6);
        // R1 reset state
        check(tune_word == 16'h0000, "R1 tune_word reset", tune_word, 0);
        check(sda_oe == 1'b0, "R1 sda_oe reset", sda_oe, 0);
        // R3 conversion request
        check(conv_cnt == 1, "R3 single conv_req pulse", conv_cnt, 1);

        // R1/R10 reset temperature through pointer + repeated START read
        m_start;
        x_addr(DEV, 1'b0, 1'b1, "R6 write address ack");
        x_ptr(8'h02);
        m_start;
        x_addr(DEV, 1'b1, 1'b1, "R2 repeated START read address");
        x_rd(1'b0, "R1 reg2 reset 0x19");
        x_rd(1'b1, "R1 reg3 reset 0x00");
        m_stop;

        // R5 tuning write
        m_start;
        x_addr(DEV, 1'b0, 1'b1, "R6 write address ack");
        x_ptr(8'h00);
        x_wr(8'hA5, "R5 write reg0");
        x_wr(8'h3C, "R5 write reg1");
        m_stop;
        check(tune_word == 16'hA53C, "R5 tune_word value", tune_word, 16'hA53C);

        // R4/R10 new sample taken at pointer byte
        push_temp(12'h1F3);
        m_start;
        x_addr(DEV, 1'b0, 1'b1, "R6 write address ack");
        x_ptr(8'h02);
        m_start;
        x_addr(DEV, 1'b1, 1'b1, "R6 read address ack");
        x_rd(1'b0, "R10 reg2 high bits");
        x_rd(1'b1, "R10 reg3 low nibble");
        m_stop;

        // R4 read-only access does not refresh; R7 wrap 3 -> 0
        push_temp(12'h0A7);
        m_start;
        x_addr(DEV, 1'b1, 1'b1, "R6 read address ack");
        x_rd(1'b0, "R7 wrapped read reg0");
        x_rd(1'b0, "R7 read reg1");
        x_rd(1'b1, "R4 reg2 keeps old snapshot");
        m_stop;

        // R5 ignored write to reg3, R7 write wrap into reg0
        m_start;
        x_addr(DEV, 1'b0, 1'b1, "R6 write address ack");
        x_ptr(8'h03);
        x_wr(8'hFF, "R5 write reg3 acked");
        x_wr(8'h12, "R7 wrapped write reg0");
        m_stop;
        check(tune_word == 16'h123C, "R7 tune_word after wrap", tune_word, 16'h123C);
        m_start;
        x_addr(DEV, 1'b0, 1'b1, "R6 write address ack");
        x_ptr(8'h02);
        m_start;
        x_addr(DEV, 1'b1, 1'b1, "R6 read address ack");
        x_rd(1'b0, "R4 reg2 refreshed");
        x_rd(1'b0, "R5 reg3 unchanged by write");
        x_rd(1'b0, "R7 read reg0 after wrap");
        x_rd(1'b1, "R7 read reg1");
        m_stop;

        // R6 address mismatch: no ack, SDA released
        m_start;
        oe_hits = 0;
        x_addr(7'h23, 1'b0, 1'b0, "R6 mismatch no ack");
        m_write(8'h00, ack);
        check(ack == 1'b0, "R6 no ack after mismatch", ack, 0);
        check(oe_hits == 0, "R6 SDA released on mismatch", oe_hits, 0);
        m_stop;
        check(tune_word == 16'h123C, "R6 tune unchanged", tune_word, 16'h123C);

        // R9 master NACK ends transmission
        m_start;
        x_addr(DEV, 1'b1, 1'b1, "R6 read address ack");
        x_rd(1'b1, "R9 byte before NACK");
        oe_hits = 0;
        m_read(1'b1, b);
        check(b == 8'hFF, "R9 bus released after NACK", b, 8'hFF);
        check(oe_hits == 0, "R9 no drive after NACK", oe_hits, 0);
        m_stop;

        // R2 STOP during read returns idle; next START still works
        m_start;
        x_addr(DEV, 1'b1, 1'b1, "R2 START after STOP");
        x_rd(1'b1, "R2 read after restart");
        m_stop;
        check(conv_cnt == 1, "R3 no further conv_req", conv_cnt, 1);

        wclk(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule